// File: doc/BRIEF.md
# Exact-Match Receive Address Filter

This block keeps a small table of station addresses and decides, for every destination address handed to it, whether that address is one the port should accept. Each table entry is written by software as two 32-bit words. The low word and the bottom half of the high word hold the 48-bit address in byte-reversed (little-endian register) form. Bit 31 of the high word is the flag that arms the entry. Entry 0 normally holds the port's own unicast address. Higher entries hold extra unicast or multicast addresses, and entries that are not in use are cleared.

The receive path presents each destination address in network order, so the first byte on the wire sits in bits 47:40. All armed entries are compared with it in parallel. One cycle later the block reports whether any entry matched and which one. When several entries match, the lowest index is reported. A global blocking input lets software load addresses without arming them.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every register word reads back as zero and no destination address produces a hit.
- R2: Register address bit 0 selects the word (0 = low, 1 = high) and the bits above it select the entry. The low word holds address bytes 0..3, with byte 0 (the first on the wire, da[47:40]) in bits 7:0 and byte 3 in bits 31:24. A low-word read returns the value written.
- R3: The high word holds byte 4 in bits 7:0 and byte 5 in bits 15:8. A high-word read returns the value written in bits 30:0. Bit 31 is the arm flag.
- R4: A destination address equal to an armed entry gives hit_valid=1, hit=1 and hit_idx equal to that entry's index, one cycle after it is presented with da_valid=1.
- R5: An entry whose high-word bit 31 is 0 never produces a hit.
- R6: An entry whose 48 address bits are all zero never produces a hit, even if bit 31 is set.
- R7: A high-word write made while av_block=1 stores bit 31 as 0. Read-back shows 0 and the entry does not hit.
- R8: When several armed entries match, hit_idx reports the lowest matching index.
- R9: hit_valid equals da_valid from one cycle earlier. When there is no hit, hit=0 and hit_idx=0.
- R10: Writing zero to both words of an entry disables it.
- R11: The comparison uses the byte order of R2 and R3. An address presented with its bytes reversed does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous to data, sampled on clk |
| av_block | input | 1 | While high, high-word writes cannot set the arm flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Write address {entry, word select} |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | IDX_W+1 | Read address {entry, word select} |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| da_valid | input | 1 | Destination address present this cycle |
| da | input | 48 | Destination address, first wire byte in bits 47:40 |
| hit_valid | output | 1 | Lookup result valid (da_valid delayed one cycle) |
| hit | output | 1 | Some armed entry matched |
| hit_idx | output | IDX_W | Lowest matching entry index |

## Verification
Register reads are combinational, so each read is checked in the same cycle it is set up: the address is driven on a falling edge and the data is sampled shortly after. A lookup result is due at the first rising edge after da_valid is driven. The bench drives da on a falling edge, lets exactly one rising edge pass, and samples hit_valid, hit and hit_idx at the next falling edge, before it removes da_valid. A write only takes effect at its rising edge, so each lookup is issued at least one full cycle after the last write it depends on.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;
    localparam int WORD_W = 32;
    localparam int MAC_W  = 48;
    localparam int ARM_BIT = 31;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MAC_W-1:0]  mac_t;

    // Rebuild a network-order address from the two little-endian words.
    function automatic mac_t words_to_mac(input word_t lo, input word_t hi);
        return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
    endfunction
endpackage

// File: rtl/rx_af_entry.sv
module rx_af_entry
    import rx_af_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_lo,
    input  logic  we_hi,
    input  logic  av_block,
    input  word_t wdata,
    input  mac_t  da,
    output word_t lo_q,
    output word_t hi_q,
    output logic  match
);
    mac_t stored;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (we_lo) lo_q <= wdata;
            if (we_hi) hi_q <= {wdata[ARM_BIT] & ~av_block, wdata[ARM_BIT-1:0]};
        end
    end

    always_comb begin
        stored = words_to_mac(lo_q, hi_q);
        match  = hi_q[ARM_BIT] && (stored != '0) && (stored == da);
    end

    // R7
    arm_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && av_block) |=> !hi_q[ARM_BIT]);
    // R6
    zero_addr_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (da != '0));
endmodule

// File: rtl/rx_af_prio.sv
module rx_af_prio #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_af_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int RA_W   = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             av_block,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic [RA_W-1:0]  reg_raddr,
    output logic [31:0]      reg_rdata,
    input  logic             da_valid,
    input  logic [47:0]      da,
    output logic             hit_valid,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    localparam int SLOTS = 1 << IDX_W;

    word_t              lo_arr [SLOTS];
    word_t              hi_arr [SLOTS];
    logic [ENTRIES-1:0] match_vec;
    logic               any_match;
    logic [IDX_W-1:0]   first_idx;
    logic [IDX_W-1:0]   wr_sel;
    logic [IDX_W-1:0]   rd_sel;

    assign wr_sel = reg_addr[RA_W-1:1];
    assign rd_sel = reg_raddr[RA_W-1:1];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < ENTRIES) begin : g_ent
            rx_af_entry u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_lo    (reg_we && !reg_addr[0] && (wr_sel == IDX_W'(g))),
                .we_hi    (reg_we &&  reg_addr[0] && (wr_sel == IDX_W'(g))),
                .av_block (av_block),
                .wdata    (reg_wdata),
                .da       (da),
                .lo_q     (lo_arr[g]),
                .hi_q     (hi_arr[g]),
                .match    (match_vec[g])
            );
        end else begin : g_pad
            assign lo_arr[g] = '0;
            assign hi_arr[g] = '0;
        end
    end

    rx_af_prio #(.N(ENTRIES), .IW(IDX_W)) u_prio (
        .req (match_vec),
        .any (any_match),
        .idx (first_idx)
    );

    assign reg_rdata = reg_raddr[0] ? hi_arr[rd_sel] : lo_arr[rd_sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit       <= 1'b0;
            hit_idx   <= '0;
        end else begin
            hit_valid <= da_valid;
            hit       <= da_valid && any_match;
            hit_idx   <= (da_valid && any_match) ? first_idx : '0;
        end
    end

    // R9
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid == $past(da_valid));
    // R9
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_valid);
    // R9
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0));
    // R4
    idx_matched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((($past(match_vec) >> hit_idx) & ENTRIES'(1)) != '0));
    // R8
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (($past(match_vec) & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = 4;
    localparam int RA_W    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             av_block = 1'b0;
    logic             reg_we = 1'b0;
    logic [RA_W-1:0]  reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [RA_W-1:0]  reg_raddr = '0;
    logic [31:0]      reg_rdata;
    logic             da_valid = 1'b0;
    logic [47:0]      da = '0;
    logic             hit_valid;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    rx_addr_filter #(.ENTRIES(ENTRIES)) i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .av_block(av_block),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .da_valid(da_valid), .da(da),
        .hit_valid(hit_valid), .hit(hit), .hit_idx(hit_idx)
    );

    // {da, expected hit, expected index}
    localparam logic [52:0] VEC [8] = '{
        {48'h021122334455, 1'b1, 4'd0},   // R4 own address
        {48'h01005E000001, 1'b1, 4'd1},   // R4 multicast entry
        {48'hAABBCCDDEE01, 1'b1, 4'd3},   // R8 entries 3 and 5
        {48'h66778899AABB, 1'b0, 4'd0},   // R5 unarmed
        {48'h000000000000, 1'b0, 4'd0},   // R6 zero address
        {48'h102030405060, 1'b0, 4'd0},   // R7 blocked arm
        {48'hF0E1D2C3B4A5, 1'b1, 4'd15},  // R4 last entry
        {48'h554433221102, 1'b0, 4'd0}    // R11 reversed bytes
    };
    localparam string VREQ [8] = '{"R4", "R4", "R8", "R5", "R6", "R7", "R4", "R11"};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_of(input logic [47:0] m);
        return {m[23:16], m[31:24], m[39:32], m[47:40]};
    endfunction

    function automatic logic [31:0] hi_of(input logic [47:0] m, input bit arm);
        return {arm, 15'h0, m[7:0], m[15:8]};
    endfunction

    task automatic wr(input int idx, input bit w, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {IDX_W'(idx), w}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input int idx, input logic [47:0] m, input bit arm);
        wr(idx, 1'b0, lo_of(m));
        wr(idx, 1'b1, hi_of(m, arm));
    endtask

    task automatic rd_chk(input int idx, input bit w, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_raddr = {IDX_W'(idx), w};
        #2;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic lookup(input logic [47:0] a, input bit eh, input logic [IDX_W-1:0] ei, input string req);
        @(negedge clk);
        da = a; da_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(hit_valid && (hit == eh) && (hit_idx == ei), req,
            {hit_valid, hit, hit_idx}, {1'b1, eh, ei});
        da_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(0, 1'b0, 32'h0, "R1");
        rd_chk(9, 1'b1, 32'h0, "R1");
        lookup(48'h0, 1'b0, '0, "R1");

        load(0,  48'h021122334455, 1'b1);
        load(1,  48'h01005E000001, 1'b1);
        load(3,  48'hAABBCCDDEE01, 1'b1);
        load(5,  48'hAABBCCDDEE01, 1'b1);
        load(4,  48'h66778899AABB, 1'b0);
        wr(6, 1'b1, 32'h8000_0000);
        av_block = 1'b1;
        load(7,  48'h102030405060, 1'b1);
        av_block = 1'b0;
        load(15, 48'hF0E1D2C3B4A5, 1'b1);

        for (int i = 0; i < 8; i++)
            lookup(VEC[i][52:5], VEC[i][4], VEC[i][3:0], VREQ[i]);

        // R2 / R3 packing and read-back
        rd_chk(0, 1'b0, 32'h33221102, "R2");
        rd_chk(0, 1'b1, 32'h80005544, "R3");
        wr(2, 1'b1, 32'h7ABC_1234);
        rd_chk(2, 1'b1, 32'h7ABC_1234, "R3");
        // R7 blocked arm reads back clear
        rd_chk(7, 1'b1, 32'h00006050, "R7");

        // R9 no lookup presented
        @(negedge clk);
        @(negedge clk);
        chk(!hit_valid && !hit && hit_idx == '0, "R9", {hit_valid, hit, hit_idx}, 0);

        // R10 disable entry 3, entry 5 now wins
        wr(3, 1'b0, 32'h0);
        wr(3, 1'b1, 32'h0);
        lookup(48'hAABBCCDDEE01, 1'b1, 4'd5, "R10");
        rd_chk(3, 1'b1, 32'h0, "R10");

        // R1 reset clears loaded entries
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(0, 1'b0, 32'h0, "R1");
        lookup(48'h021122334455, 1'b0, '0, "R1");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule